// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a watchdog countdown timer that software reaches through a plain 32-bit register port: byte address, write strobe, write data and combinational read data. Software stores a reload value and then turns the timer on by setting the enable bit in the control word. From then on a down-counter runs. Its time base is either every cycle of the peripheral clock or a microsecond tick that an internal prescaler divides down from that clock.

To keep the system alive, software must write a 16-bit key to the restart word before the count runs out. That write copies the reload value back into the counter. If the counter gets to zero, the block stops counting. It then raises whichever timeout actions the control word selects:
- a one-cycle system reset request, which carries a reset-scope indication;
- a sticky interrupt;
- a one-cycle external strobe.

Only the live count, the reload value and the control word are backed by storage. Every other location reads as zero and ignores writes.

Top module: `wdog_keyed_top`

## Requirements
- R1: After reset, the count word (offset 0x00) and the reload word (offset 0x04) both read 0x03EF1480. The control word (offset 0x0C) reads 0. rst_req, rst_full_chip, irq and ext_pulse are all low.
- R2: The reload word at 0x04 reads back the full 32 bits last written. The control word at 0x0C keeps only bits [5:0]; bits [31:6] read as 0.
- R3: A write to the restart word (0x08) whose bits [15:0] equal 0x4755 copies the reload value into the counter. Counting then resumes if the timer is enabled and does not resume if it is disabled. A restart write with any other low half leaves the count untouched. Reading 0x08 returns 0.
- R4: A write to the control word changes the control register only when written bit 0 differs from the current enable bit. Otherwise the whole write, all bits included, has no effect.
- R5: A control write that changes bit 0 from 0 to 1 loads the counter from the reload value and starts the countdown. A write that changes it from 1 to 0 stops the countdown, and the count keeps its value.
- R6: With control bit 4 = 0, the counter drops by one on every clock cycle. With reload N ≥ 1, the counter reaches 0 N cycles after the loading edge. With reload 0, timeout occurs on the first cycle.
- R7: With control bit 4 = 1, the counter drops by one every PRESCALE_DIV cycles (24 by default). The first decrement comes PRESCALE_DIV cycles after the loading edge.
- R8: At timeout the count reads 0, and it stays at 0 with counting stopped until a new load.
- R9: At timeout with control bit 1 set, rst_req is high for exactly one cycle. During that cycle rst_full_chip equals control bit 5. rst_full_chip is low at all other times.
- R10: At timeout with control bit 2 set, irq goes high and stays high. It is cleared by a keyed restart or by a 0-to-1 enable write. A 1-to-0 enable write does not clear it.
- R11: At timeout with control bit 3 set, ext_pulse is high for exactly one cycle.
- R12: The following writes have no effect: writes to the count word (0x00), writes to 0x10, 0x14, 0x18 or unmapped offsets, and writes to addresses that are not word-aligned. Reads of 0x10, 0x14, 0x18, unmapped offsets and misaligned addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| rst_req | output | 1 | One-cycle system reset request at timeout |
| rst_full_chip | output | 1 | Reset scope during rst_req: 1 = full chip, 0 = SoC only |
| irq | output | 1 | Sticky timeout interrupt |
| ext_pulse | output | 1 | One-cycle external timeout strobe |

## Verification
The embedded assertions check the following on every cycle:
- the reset request and the external strobe are single cycles;
- the reset scope never appears without a request;
- the interrupt holds until a load;
- a stopped counter keeps its value;
- each running tick takes exactly one from the count;
- a control write that keeps the enable bit leaves the register alone;
- a keyed restart lands the reload value in the count on the next cycle.

Some behaviour is visible only in the bench's timed scenarios: the exact cycle of expiry in both time bases, the full sweep of action-bit combinations against reload values, the handling of wrong keys, and the silence of unimplemented and misaligned locations.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned WD_DATA_W = 32;
    localparam logic [15:0] WD_RESTART_KEY = 16'h4755;

    // Word index of each location (byte offset / 4)
    typedef enum logic [2:0] {
        REG_COUNT     = 3'd0,
        REG_RELOAD    = 3'd1,
        REG_KICK      = 3'd2,
        REG_CTRL      = 3'd3,
        REG_TO_STAT   = 3'd4,
        REG_TO_CLR    = 3'd5,
        REG_RST_WIDTH = 3'd6,
        REG_NONE      = 3'd7
    } wd_reg_e;

    // Control word, bit 0 first from the right
    typedef struct packed {
        logic full_chip;   // bit 5
        logic slow_clk;    // bit 4
        logic ext_en;      // bit 3
        logic irq_en;      // bit 2
        logic rst_en;      // bit 1
        logic enable;      // bit 0
    } wd_ctrl_t;

    localparam int unsigned WD_CTRL_W = $bits(wd_ctrl_t);

    // Load / stop command from the register file to the counter
    typedef struct packed {
        logic                 load;
        logic                 start;
        logic                 stop;
        logic [WD_DATA_W-1:0] value;
    } wd_cmd_t;

    function automatic logic wd_key_ok(input logic [WD_DATA_W-1:0] d);
        return d[15:0] == WD_RESTART_KEY;
    endfunction

    function automatic wd_ctrl_t wd_ctrl_from_word(input logic [WD_DATA_W-1:0] d);
        return wd_ctrl_t'(d[WD_CTRL_W-1:0]);
    endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int unsigned          ADDR_W      = 8,
    parameter logic [WD_DATA_W-1:0] RESET_COUNT = 32'h03EF1480
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [WD_DATA_W-1:0] bus_wdata,
    output logic [WD_DATA_W-1:0] bus_rdata,
    input  logic [WD_DATA_W-1:0] count_i,
    output wd_ctrl_t             ctrl_o,
    output logic [WD_DATA_W-1:0] reload_o,
    output wd_cmd_t              cmd_o
);

    localparam int unsigned IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] NUM_WORDS = IDX_W'(7);

    logic [IDX_W-1:0]     widx;
    wd_reg_e              sel;
    wd_ctrl_t             ctrl_q;
    wd_ctrl_t             ctrl_new;
    logic [WD_DATA_W-1:0] reload_q;
    logic                 ctrl_wr;
    logic                 en_flip;
    logic                 kick;

    assign widx = bus_addr[ADDR_W-1:2];

    always_comb begin
        sel = REG_NONE;
        if (bus_addr[1:0] == 2'b00 && widx < NUM_WORDS) begin
            sel = wd_reg_e'(widx[2:0]);
        end
    end

    assign ctrl_new = wd_ctrl_from_word(bus_wdata);
    assign ctrl_wr  = bus_wr && (sel == REG_CTRL);
    assign en_flip  = ctrl_new.enable != ctrl_q.enable;
    assign kick     = bus_wr && (sel == REG_KICK) && wd_key_ok(bus_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            reload_q <= RESET_COUNT;
        end else begin
            if (ctrl_wr && en_flip) begin
                ctrl_q <= ctrl_new;
            end
            if (bus_wr && sel == REG_RELOAD) begin
                reload_q <= bus_wdata;
            end
        end
    end

    always_comb begin
        cmd_o.load  = kick || (ctrl_wr && en_flip && ctrl_new.enable);
        cmd_o.start = (ctrl_wr && en_flip) ? ctrl_new.enable : ctrl_q.enable;
        cmd_o.stop  = ctrl_wr && en_flip && !ctrl_new.enable;
        cmd_o.value = reload_q;
    end

    always_comb begin
        unique case (sel)
            REG_COUNT:  bus_rdata = count_i;
            REG_RELOAD: bus_rdata = reload_q;
            REG_CTRL:   bus_rdata = WD_DATA_W'(ctrl_q);
            default:    bus_rdata = '0;
        endcase
    end

    assign ctrl_o   = ctrl_q;
    assign reload_o = reload_q;

    AST_CTRL_SAME_EN_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !en_flip) |=> $stable(ctrl_q)); // R4

endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int unsigned DIV = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic run_i,
    input  logic slow_i,
    output logic tick_o
);

    generate
        if (DIV <= 1) begin : g_passthru
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int unsigned PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);

            logic [PW-1:0] pcnt;

            always_ff @(posedge clk) begin
                if (rst || clear_i || !run_i || !slow_i) begin
                    pcnt <= '0;
                end else if (pcnt == LAST) begin
                    pcnt <= '0;
                end else begin
                    pcnt <= pcnt + 1'b1;
                end
            end

            assign tick_o = slow_i ? (pcnt == LAST) : 1'b1;
        end
    endgenerate

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter logic [WD_DATA_W-1:0] RESET_COUNT = 32'h03EF1480
) (
    input  logic                 clk,
    input  logic                 rst,
    input  wd_cmd_t              cmd_i,
    input  wd_ctrl_t             ctrl_i,
    input  logic                 tick_i,
    output logic [WD_DATA_W-1:0] count_o,
    output logic                 running_o,
    output logic                 rst_req_o,
    output logic                 rst_full_o,
    output logic                 irq_o,
    output logic                 ext_o
);

    logic [WD_DATA_W-1:0] count_q;
    logic                 run_q;
    logic                 expire;

    assign expire = run_q && ctrl_i.enable && tick_i && (count_q <= 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q    <= RESET_COUNT;
            run_q      <= 1'b0;
            rst_req_o  <= 1'b0;
            rst_full_o <= 1'b0;
            irq_o      <= 1'b0;
            ext_o      <= 1'b0;
        end else begin
            rst_req_o  <= 1'b0;
            rst_full_o <= 1'b0;
            ext_o      <= 1'b0;
            if (cmd_i.load) begin
                count_q <= cmd_i.value;
                run_q   <= cmd_i.start;
                irq_o   <= 1'b0;
            end else if (cmd_i.stop) begin
                run_q <= 1'b0;
            end else if (expire) begin
                count_q    <= '0;
                run_q      <= 1'b0;
                rst_req_o  <= ctrl_i.rst_en;
                rst_full_o <= ctrl_i.rst_en && ctrl_i.full_chip;
                ext_o      <= ctrl_i.ext_en;
                if (ctrl_i.irq_en) begin
                    irq_o <= 1'b1;
                end
            end else if (run_q && ctrl_i.enable && tick_i) begin
                count_q <= count_q - 1'b1;
            end
        end
    end

    assign count_o   = count_q;
    assign running_o = run_q;

    AST_RST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |=> !rst_req_o); // R9
    AST_SCOPE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        rst_full_o |-> rst_req_o); // R9
    AST_REQ_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |-> (count_q == '0)); // R8
    AST_EXT_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ext_o |=> !ext_o); // R11
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !cmd_i.load) |=> irq_o); // R10
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !cmd_i.load) |=> $stable(count_q)); // R5
    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        (run_q && tick_i && !cmd_i.load && !cmd_i.stop && count_q > 1)
        |=> (count_q == $past(count_q) - 1)); // R6

endmodule

// File: rtl/wdog_keyed_top.sv
module wdog_keyed_top
    import wdog_pkg::*;
#(
    parameter int unsigned          ADDR_W       = 8,
    parameter int unsigned          PRESCALE_DIV = 24,
    parameter logic [WD_DATA_W-1:0] RESET_COUNT  = 32'h03EF1480
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [WD_DATA_W-1:0] bus_wdata,
    output logic [WD_DATA_W-1:0] bus_rdata,
    output logic                 rst_req,
    output logic                 rst_full_chip,
    output logic                 irq,
    output logic                 ext_pulse
);

    localparam logic [ADDR_W-1:0] KICK_ADDR = ADDR_W'(8);

    wd_ctrl_t             ctrl;
    wd_cmd_t              cmd;
    logic [WD_DATA_W-1:0] count;
    logic [WD_DATA_W-1:0] reload;
    logic                 running;
    logic                 tick;

    wdog_regs #(
        .ADDR_W      (ADDR_W),
        .RESET_COUNT (RESET_COUNT)
    ) regs_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .count_i   (count),
        .ctrl_o    (ctrl),
        .reload_o  (reload),
        .cmd_o     (cmd)
    );

    wdog_prescale #(
        .DIV (PRESCALE_DIV)
    ) presc_i (
        .clk     (clk),
        .rst     (rst),
        .clear_i (cmd.load),
        .run_i   (running),
        .slow_i  (ctrl.slow_clk),
        .tick_o  (tick)
    );

    wdog_core #(
        .RESET_COUNT (RESET_COUNT)
    ) core_i (
        .clk        (clk),
        .rst        (rst),
        .cmd_i      (cmd),
        .ctrl_i     (ctrl),
        .tick_i     (tick),
        .count_o    (count),
        .running_o  (running),
        .rst_req_o  (rst_req),
        .rst_full_o (rst_full_chip),
        .irq_o      (irq),
        .ext_o      (ext_pulse)
    );

    AST_KEY_LOADS_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == KICK_ADDR && wd_key_ok(bus_wdata))
        |=> (count == $past(reload))); // R3

endmodule

// File: tb/wdog_keyed_top_tb.sv
module wdog_keyed_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DIV = 24;
    localparam logic [31:0] RST_VAL = 32'h03EF1480;
    localparam logic [7:0] A_CNT = 8'h00, A_RLD = 8'h04, A_KICK = 8'h08, A_CTRL = 8'h0C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req, rst_full_chip, irq, ext_pulse;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_keyed_top dut_i (
        .clk           (clk),
        .rst           (rst),
        .bus_addr      (bus_addr),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .rst_req       (rst_req),
        .rst_full_chip (rst_full_chip),
        .irq           (irq),
        .ext_pulse     (ext_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic chk_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic waitc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        waitc(3);
        rst = 1'b0;
        waitc(1);

        // R1 reset state
        chk_rd("R1 count", A_CNT, RST_VAL);
        chk_rd("R1 reload", A_RLD, RST_VAL);
        chk_rd("R1 ctrl", A_CTRL, 32'h0);
        chk("R1 outputs", {28'h0, rst_req, rst_full_chip, irq, ext_pulse}, 32'h0);

        // R12 ignored locations
        wr(A_CNT, 32'h5);
        chk_rd("R12 count write ignored", A_CNT, RST_VAL);
        for (int a = 16; a < 64; a += 4) wr(8'(a), 32'hFFFF_FFFF);
        wr(8'h05, 32'h0000_0077);
        wr(8'h0D, 32'h0000_0001);
        chk_rd("R12 reload untouched", A_RLD, RST_VAL);
        chk_rd("R12 ctrl untouched", A_CTRL, 32'h0);
        for (int a = 16; a < 64; a += 4) chk_rd("R12 unimplemented reads 0", 8'(a), 32'h0);
        chk_rd("R12 misaligned reads 0", 8'h05, 32'h0);
        chk_rd("R3 restart reads 0", A_KICK, 32'h0);

        // R2 / R4 control gating
        wr(A_RLD, 32'hA5A5_1234);
        chk_rd("R2 reload readback", A_RLD, 32'hA5A5_1234);
        wr(A_CTRL, 32'h0000_003E);
        chk_rd("R4 same enable ignored", A_CTRL, 32'h0);
        wr(A_CTRL, 32'hFFFF_FFD1);
        chk_rd("R2 ctrl upper zero", A_CTRL, 32'h11);
        wr(A_CTRL, 32'h0000_0003);
        chk_rd("R4 same enable ignored while on", A_CTRL, 32'h11);

        // R3 / R5 fast count, key and stop
        wr(A_CTRL, 32'h0);
        chk_rd("R5 disable applied", A_CTRL, 32'h0);
        wr(A_RLD, 32'd100);
        wr(A_CTRL, 32'h1);
        chk_rd("R5 enable loads", A_CNT, 32'd100);
        waitc(10);
        chk_rd("R6 fast decrement", A_CNT, 32'd90);
        wr(A_KICK, 32'h1234_4756);
        chk_rd("R3 wrong key ignored", A_CNT, 32'd89);
        wr(A_KICK, 32'hABCD_4755);
        chk_rd("R3 key reloads", A_CNT, 32'd100);
        waitc(5);
        chk_rd("R6 after key", A_CNT, 32'd95);
        wr(A_CTRL, 32'h0);
        chk_rd("R5 stop holds", A_CNT, 32'd95);
        waitc(5);
        chk_rd("R5 still held", A_CNT, 32'd95);
        wr(A_KICK, 32'h0000_4755);
        chk_rd("R3 key while disabled", A_CNT, 32'd100);
        waitc(3);
        chk_rd("R3 disabled stays", A_CNT, 32'd100);

        // R7 slow time base
        wr(A_RLD, 32'd2);
        wr(A_CTRL, 32'h15);
        waitc(DIV - 1);
        chk_rd("R7 before first tick", A_CNT, 32'd2);
        waitc(1);
        chk_rd("R7 first tick", A_CNT, 32'd1);
        waitc(DIV - 1);
        chk_rd("R7 before expiry", A_CNT, 32'd1);
        chk("R7 irq low before", {31'h0, irq}, 32'h0);
        waitc(1);
        chk_rd("R7 expiry", A_CNT, 32'd0);
        chk("R7 irq at expiry", {31'h0, irq}, 32'h1);

        // Sweep of action bits against reload values
        for (int c = 0; c < 16; c++) begin
            for (int n = 1; n <= 4; n++) begin
                logic b_rst, b_irq, b_ext, b_full;
                logic [31:0] cv;
                b_rst  = c[0];
                b_irq  = c[1];
                b_ext  = c[2];
                b_full = c[3];
                cv = 32'h1 | ({31'h0, b_rst} << 1) | ({31'h0, b_irq} << 2)
                           | ({31'h0, b_ext} << 3) | ({31'h0, b_full} << 5);
                wr(A_CTRL, 32'h0);
                wr(A_RLD, 32'(n));
                wr(A_CTRL, cv);
                waitc(n - 1);
                chk_rd("R6 one before timeout", A_CNT, 32'd1);
                chk("R9 no early req", {31'h0, rst_req}, 32'h0);
                chk("R10 irq cleared by enable", {31'h0, irq}, 32'h0);
                waitc(1);
                chk_rd("R8 zero at timeout", A_CNT, 32'd0);
                chk("R9 req", {31'h0, rst_req}, {31'h0, b_rst});
                chk("R9 scope", {31'h0, rst_full_chip}, {31'h0, b_rst & b_full});
                chk("R10 irq set", {31'h0, irq}, {31'h0, b_irq});
                chk("R11 ext", {31'h0, ext_pulse}, {31'h0, b_ext});
                waitc(1);
                chk("R9 req one cycle", {31'h0, rst_req}, 32'h0);
                chk("R11 ext one cycle", {31'h0, ext_pulse}, 32'h0);
                chk("R10 irq sticky", {31'h0, irq}, {31'h0, b_irq});
                waitc(3);
                chk_rd("R8 stays zero", A_CNT, 32'd0);
            end
        end

        // R10 keyed restart clears irq and rearms
        wr(A_KICK, 32'h0000_4755);
        chk("R10 key clears irq", {31'h0, irq}, 32'h0);
        chk_rd("R3 rearm count", A_CNT, 32'd4);
        waitc(3);
        chk_rd("R3 rearm counting", A_CNT, 32'd1);
        waitc(1);
        chk("R10 irq again", {31'h0, irq}, 32'h1);
        wr(A_KICK, 32'h4755_0000);
        chk("R3 wrong key keeps irq", {31'h0, irq}, 32'h1);
        chk_rd("R3 wrong key keeps zero", A_CNT, 32'd0);
        wr(A_CTRL, 32'h0);
        chk("R10 disable keeps irq", {31'h0, irq}, 32'h1);

        // R6 reload of zero
        wr(A_RLD, 32'd0);
        wr(A_CTRL, 32'h5);
        chk("R10 enable clears irq", {31'h0, irq}, 32'h0);
        waitc(1);
        chk("R6 zero reload fires first cycle", {31'h0, irq}, 32'h1);
        chk_rd("R8 zero reload count", A_CNT, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule